// File: doc/BRIEF.md
# Round-Trip Latency Probe

This block measures how long a word takes to go out over a FIFO-style word channel and come back. A processor writes a start command into a small register block. The probe waits until the outbound channel can take a word, writes one tagged word, and starts counting clock cycles from the cycle that write is accepted. It stops counting on the cycle it reads the matching reply from the inbound channel. It then latches the elapsed count, which the processor can read.

Each outgoing word carries a tag taken from a rolling counter. A reply that carries a different tag is read and discarded. It raises a mismatch flag, and the measurement keeps running. If no matching reply arrives before the cycle counter reaches all ones, the probe stops, reports a timeout and latches the all-ones count.

The same core can be switched into a responder mode. In that mode it acts as the far-end peer: every word read from the inbound channel is written back unchanged on the outbound channel in the same cycle.

Top module: `rtt_probe`

## Requirements
- R1: A write to the control register (address 0) with bit 0 set and bit 1 clear, while idle, sets busy and increments the tag (modulo 2^TAG_W; the first tag after reset is 1). It then writes exactly one outbound word whose low TAG_W bits are the tag and whose upper bits are zero.
- R2: The outbound word is written only in a cycle where tx_full is low. While tx_full is high the probe waits with tx_wr low.
- R3: The latched count equals the number of clock cycles from the cycle the outbound write is accepted to the cycle the matching reply is read. A reply read d cycles later gives count d.
- R4: When a matching reply is read, busy clears and the done bit is set. The count register (address 2) holds the result until the next accepted start.
- R5: An inbound word whose low TAG_W bits differ from the outstanding tag is read and discarded. It sets the mismatch bit, and the measurement continues.
- R6: If the cycle counter reaches 2^CNT_W-1 without a matching reply, the probe stops. It sets the timeout bit, clears busy and latches the count as all ones. The counter never wraps.
- R7: Control-register writes made while busy are ignored, both for start and for the mode bit.
- R8: With control bit 1 set (responder mode, read back at address 0 bit 1), an inbound word is read only when tx_full is low. It is written back unchanged in the same cycle, so rx_rd equals tx_wr. Start commands are ignored in this mode.
- R9: After reset, the status, count, tag and mode registers read zero, and tx_wr and rx_rd are low.
- R10: An accepted start clears the done, timeout and mismatch bits. The status layout at address 1 is: bit 0 busy, bit 1 done, bit 2 timeout, bit 3 mismatch.
- R11: In initiator mode the probe does not read the inbound channel while idle. Address 3 reads the current tag, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_full | input | 1 | Outbound channel cannot accept a word |
| tx_wr | output | 1 | Outbound write strobe |
| tx_data | output | DATA_W | Outbound word |
| rx_empty | input | 1 | Inbound channel holds no word |
| rx_rd | output | 1 | Inbound read strobe |
| rx_data | input | DATA_W | Inbound word |

## Verification
The assertions check several properties on every cycle:
- no outbound write while the channel is full, and no inbound read while it is empty;
- at most one outbound write per measurement;
- the tag holds steady while a busy probe sees start commands;
- a mismatched reply never ends a run;
- a saturated counter stays saturated;
- in responder mode, reads and writes are paired with identical data.

The exact latched count for each reply delay, the timeout after the full counter span, the clearing of flags, and the effect of register writes made while busy are shown only by the bench. It sweeps reply delays, stall lengths and stray replies, and computes each expected count arithmetically.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

   localparam int REG_AW = 2;
   localparam int REG_DW = 32;

   localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd0;
   localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd1;
   localparam logic [REG_AW-1:0] ADDR_COUNT  = 2'd2;
   localparam logic [REG_AW-1:0] ADDR_TAG    = 2'd3;

   localparam int CTRL_GO_BIT   = 0;
   localparam int CTRL_MODE_BIT = 1;

   localparam int STAT_BUSY_BIT = 0;
   localparam int STAT_DONE_BIT = 1;
   localparam int STAT_TMO_BIT  = 2;
   localparam int STAT_MIS_BIT  = 3;

   typedef enum logic [1:0] {
      PR_IDLE = 2'd0,
      PR_SEND = 2'd1,
      PR_WAIT = 2'd2
   } probe_state_e;

   typedef struct packed {
      logic busy;
      logic done;
      logic timeout;
      logic mismatch;
   } probe_flags_t;

endpackage

// File: rtl/rtt_sat_counter.sv
module rtt_sat_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   output logic [CNT_W-1:0] cnt,
   output logic             last_step,
   output logic             sat
);
   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt_q <= '0;
      else if (clr)         cnt_q <= '0;
      else if (en && !sat)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt       = cnt_q;
   assign sat       = (cnt_q == CNT_MAX);
   assign last_step = (cnt_q == CNT_LAST);

   AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sat && !clr) |=> sat) else $error("counter left saturation"); // R6

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && !sat) |=> (cnt == $past(cnt) + 1'b1)) else $error("counter step"); // R3

endmodule

// File: rtl/rtt_initiator.sv
module rtt_initiator
   import rtt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tx_full,
   output logic              tx_wr,
   output logic [DATA_W-1:0] tx_data,
   input  logic              rx_empty,
   output logic              rx_rd,
   input  logic [DATA_W-1:0] rx_data,
   output probe_flags_t      flags,
   output logic [CNT_W-1:0]  result,
   output logic [TAG_W-1:0]  tag
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam int PAD_W = DATA_W - TAG_W;

   probe_state_e     state_q;
   logic [TAG_W-1:0] tag_q;
   logic [CNT_W-1:0] result_q;
   logic             done_q, tmo_q, mis_q;

   logic [CNT_W-1:0] cnt;
   logic             last_step, sat;
   logic             accept, wait_st, match, stray, tmo_hit, go;

   assign go      = start && (state_q == PR_IDLE);
   assign tx_wr   = (state_q == PR_SEND) && !tx_full;
   assign accept  = tx_wr;
   assign wait_st = (state_q == PR_WAIT);
   assign rx_rd   = wait_st && !rx_empty;
   assign match   = rx_rd && (rx_data[TAG_W-1:0] == tag_q);
   assign stray   = rx_rd && !match;
   assign tmo_hit = wait_st && !match && (last_step || sat);
   assign tx_data = {{PAD_W{1'b0}}, tag_q};

   rtt_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .en        (wait_st),
      .cnt       (cnt),
      .last_step (last_step),
      .sat       (sat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= PR_IDLE;
         tag_q    <= '0;
         result_q <= '0;
         done_q   <= 1'b0;
         tmo_q    <= 1'b0;
         mis_q    <= 1'b0;
      end else begin
         unique case (state_q)
            PR_IDLE: if (go) begin
               state_q <= PR_SEND;
               tag_q   <= tag_q + 1'b1;
               done_q  <= 1'b0;
               tmo_q   <= 1'b0;
               mis_q   <= 1'b0;
            end
            PR_SEND: if (accept) state_q <= PR_WAIT;
            PR_WAIT: begin
               if (match) begin
                  state_q  <= PR_IDLE;
                  done_q   <= 1'b1;
                  result_q <= cnt + 1'b1;
               end else if (tmo_hit) begin
                  state_q  <= PR_IDLE;
                  tmo_q    <= 1'b1;
                  result_q <= CNT_MAX;
               end
               if (stray) mis_q <= 1'b1;
            end
            default: state_q <= PR_IDLE;
         endcase
      end
   end

   assign flags.busy     = (state_q != PR_IDLE);
   assign flags.done     = done_q;
   assign flags.timeout  = tmo_q;
   assign flags.mismatch = mis_q;
   assign result         = result_q;
   assign tag            = tag_q;

   AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> !tx_wr) else $error("second outbound word"); // R1

   AST_NO_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |-> !tx_full) else $error("write while full"); // R2

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.busy && start) |=> (tag == $past(tag))) else $error("start taken while busy"); // R7

   AST_STRAY_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
      (stray && !tmo_hit) |=> flags.busy) else $error("stray reply ended run"); // R5

   AST_MATCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> (!flags.busy && flags.done)) else $error("match did not end run"); // R4

   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !flags.busy |-> !rx_rd) else $error("read while idle"); // R11

   AST_TIMEOUT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags.timeout) |-> (result == CNT_MAX)) else $error("timeout count"); // R6

endmodule

// File: rtl/rtt_responder.sv
module rtt_responder #(
   parameter int DATA_W = 32
) (
   input  logic              en,
   input  logic              rx_empty,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_rd,
   input  logic              tx_full,
   output logic              tx_wr,
   output logic [DATA_W-1:0] tx_data
);
   logic pass;

   assign pass    = en && !rx_empty && !tx_full;
   assign rx_rd   = pass;
   assign tx_wr   = pass;
   assign tx_data = rx_data;

endmodule

// File: rtl/rtt_regs.sv
module rtt_regs
   import rtt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int TAG_W   = 8,
   parameter bit RESP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  probe_flags_t      flags,
   input  logic [CNT_W-1:0]  result,
   input  logic [TAG_W-1:0]  tag,
   output logic              start,
   output logic              resp_mode
);
   logic ctrl_wr;

   assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL) && !flags.busy;
   assign start   = ctrl_wr && reg_wdata[CTRL_GO_BIT] && !reg_wdata[CTRL_MODE_BIT];

   generate
      if (RESP_EN) begin : g_mode
         logic mode_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       mode_q <= 1'b0;
            else if (ctrl_wr) mode_q <= reg_wdata[CTRL_MODE_BIT];
         end
         assign resp_mode = mode_q;
      end else begin : g_no_mode
         assign resp_mode = 1'b0;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_CTRL:   reg_rdata[CTRL_MODE_BIT] = resp_mode;
         ADDR_STATUS: begin
            reg_rdata[STAT_BUSY_BIT] = flags.busy;
            reg_rdata[STAT_DONE_BIT] = flags.done;
            reg_rdata[STAT_TMO_BIT]  = flags.timeout;
            reg_rdata[STAT_MIS_BIT]  = flags.mismatch;
         end
         ADDR_COUNT:  reg_rdata[CNT_W-1:0] = result;
         ADDR_TAG:    reg_rdata[TAG_W-1:0] = tag;
         default:     reg_rdata = '0;
      endcase
   end

   AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      flags.busy |=> $stable(resp_mode)) else $error("mode changed while busy"); // R7

endmodule

// File: rtl/rtt_probe.sv
module rtt_probe
   import rtt_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int TAG_W   = 8,
   parameter int CNT_W   = 32,
   parameter bit RESP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              tx_full,
   output logic              tx_wr,
   output logic [DATA_W-1:0] tx_data,
   input  logic              rx_empty,
   output logic              rx_rd,
   input  logic [DATA_W-1:0] rx_data
);
   generate
      if (CNT_W < 16 || CNT_W > REG_DW) begin : g_bad_cnt
         $error("CNT_W must lie between 16 and the register width");
      end
      if (TAG_W < 1 || TAG_W >= DATA_W) begin : g_bad_tag
         $error("TAG_W must be at least 1 and below DATA_W");
      end
   endgenerate

   probe_flags_t      flags;
   logic [CNT_W-1:0]  result;
   logic [TAG_W-1:0]  tag;
   logic              start, resp_mode;

   logic              i_tx_wr, i_rx_rd;
   logic [DATA_W-1:0] i_tx_data;
   logic              r_tx_wr, r_rx_rd;
   logic [DATA_W-1:0] r_tx_data;

   rtt_regs #(.CNT_W(CNT_W), .TAG_W(TAG_W), .RESP_EN(RESP_EN)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .flags     (flags),
      .result    (result),
      .tag       (tag),
      .start     (start),
      .resp_mode (resp_mode)
   );

   rtt_initiator #(.DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_init (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tx_full  (tx_full),
      .tx_wr    (i_tx_wr),
      .tx_data  (i_tx_data),
      .rx_empty (rx_empty),
      .rx_rd    (i_rx_rd),
      .rx_data  (rx_data),
      .flags    (flags),
      .result   (result),
      .tag      (tag)
   );

   generate
      if (RESP_EN) begin : g_resp
         rtt_responder #(.DATA_W(DATA_W)) u_resp (
            .en       (resp_mode),
            .rx_empty (rx_empty),
            .rx_data  (rx_data),
            .rx_rd    (r_rx_rd),
            .tx_full  (tx_full),
            .tx_wr    (r_tx_wr),
            .tx_data  (r_tx_data)
         );
      end else begin : g_no_resp
         assign r_rx_rd   = 1'b0;
         assign r_tx_wr   = 1'b0;
         assign r_tx_data = '0;
      end
   endgenerate

   assign tx_wr   = resp_mode ? r_tx_wr   : i_tx_wr;
   assign tx_data = resp_mode ? r_tx_data : i_tx_data;
   assign rx_rd   = resp_mode ? r_rx_rd   : i_rx_rd;

   AST_ECHO_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      resp_mode |-> (rx_rd == tx_wr)) else $error("echo unpaired"); // R8

   AST_ECHO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_mode && tx_wr) |-> (tx_data == rx_data)) else $error("echo data"); // R8

   AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd |-> !rx_empty) else $error("read while empty"); // R11

   AST_ECHO_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      resp_mode |-> !flags.busy) else $error("busy in responder mode"); // R8

endmodule

// File: tb/rtt_probe_tb_top.sv
module rtt_probe_tb_top;
   localparam int DW = 16;
   localparam int TW = 4;
   localparam int CW = 16;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          tx_full = 1'b0;
   logic          tx_wr;
   logic [DW-1:0] tx_data;
   logic          rx_empty = 1'b1;
   logic          rx_rd;
   logic [DW-1:0] rx_data = '0;

   int checks = 0;
   int errors = 0;
   int exp_tag = 0;

   always #4 clk = ~clk;

   rtt_probe #(.DATA_W(DW), .TAG_W(TW), .CNT_W(CW), .RESP_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_full(tx_full),
      .tx_wr(tx_wr), .tx_data(tx_data), .rx_empty(rx_empty), .rx_rd(rx_rd),
      .rx_data(rx_data)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic run_meas(input int hold, input int d, input bit mm);
      logic [31:0] v;
      tx_full  = (hold > 0);
      rx_empty = 1'b1;
      reg_write(2'd0, 32'd1);
      exp_tag = (exp_tag + 1) % (1 << TW);
      reg_read(2'd1, v);
      chk("R1 busy after start", v[0], 1);
      chk("R10 flags cleared on start", v[3:1], 0);
      for (int i = 0; i < hold; i++) begin
         #1 chk("R2 no write while full", tx_wr, 0);
         @(negedge clk);
      end
      tx_full = 1'b0;
      #1;
      chk("R1 word written", tx_wr, 1);
      chk("R1 word carries tag", tx_data, exp_tag);
      for (int i = 1; i <= d; i++) begin
         @(negedge clk);
         if (i == d) begin
            rx_empty = 1'b0; rx_data = 16'h5A50 | exp_tag[TW-1:0];
         end else if (mm && i == 1) begin
            rx_empty = 1'b0; rx_data = 16'h5A50 | ((exp_tag + 1) % (1 << TW));
         end else begin
            rx_empty = 1'b1;
         end
         #1;
         chk("R1 single word only", tx_wr, 0);
         if (i == d) chk("R3 reply read", rx_rd, 1);
      end
      @(negedge clk);
      rx_empty = 1'b1;
      reg_read(2'd1, v);
      chk("R4 busy clear", v[0], 0);
      chk("R4 done set", v[1], 1);
      chk("R5 mismatch flag", v[3], mm);
      chk("R6 no timeout", v[2], 0);
      reg_read(2'd2, v);
      chk("R3 latched count", v, d);
      reg_read(2'd3, v);
      chk("R11 tag readback", v, exp_tag);
   endtask

   initial begin
      logic [31:0] v;
      int j;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      rx_empty = 1'b0;
      reg_read(2'd0, v); chk("R9 mode after reset", v, 0);
      reg_read(2'd1, v); chk("R9 status after reset", v, 0);
      reg_read(2'd2, v); chk("R9 count after reset", v, 0);
      reg_read(2'd3, v); chk("R9 tag after reset", v, 0);
      chk("R9 tx_wr low", tx_wr, 0);
      chk("R11 no read while idle", rx_rd, 0);
      rx_empty = 1'b1;

      // R3 R5 sweep over stall lengths and reply delays
      for (int h = 0; h < 5; h++)
         for (int d = 1; d <= 24; d++)
            run_meas(h, d, (d >= 2) && (d % 3 == 0));

      // R4 result holds while idle
      repeat (5) @(negedge clk);
      reg_read(2'd2, v); chk("R4 count holds", v, 24);

      // R7 control writes ignored while busy
      tx_full = 1'b0;
      reg_write(2'd0, 32'd1);
      exp_tag = (exp_tag + 1) % (1 << TW);
      #1 chk("R7 setup write", tx_wr, 1);
      reg_write(2'd0, 32'd3);
      reg_read(2'd0, v); chk("R7 mode unchanged while busy", v, 0);
      reg_read(2'd3, v); chk("R7 tag unchanged while busy", v, exp_tag);
      @(negedge clk);
      rx_empty = 1'b0; rx_data = exp_tag[DW-1:0];
      @(negedge clk);
      rx_empty = 1'b1;
      reg_read(2'd2, v); chk("R7 count after ignored write", v, 3);

      // R6 timeout
      reg_write(2'd0, 32'd1);
      exp_tag = (exp_tag + 1) % (1 << TW);
      #1 chk("R6 setup write", tx_wr, 1);
      j = 0;
      while (j < 70000) begin
         @(negedge clk);
         j++;
         reg_read(2'd1, v);
         if (v[0] == 1'b0) break;
      end
      chk("R6 cycles until timeout", j, CMAX + 1);
      chk("R6 timeout bit", v[2], 1);
      chk("R6 done clear", v[1], 0);
      reg_read(2'd2, v); chk("R6 saturated count", v, CMAX);
      rx_empty = 1'b0;
      #1 chk("R11 idle after timeout no read", rx_rd, 0);
      rx_empty = 1'b1;

      // R8 responder mode
      reg_write(2'd0, 32'd2);
      reg_read(2'd0, v); chk("R8 mode readback", v[1], 1);
      for (int p = 0; p < 64; p++) begin
         @(negedge clk);
         rx_empty = p[0];
         tx_full  = p[1] & p[3];
         rx_data  = 16'(p * 977 + 13);
         #1;
         chk("R8 read gating", rx_rd, (!rx_empty && !tx_full));
         chk("R8 write paired", tx_wr, rx_rd);
         if (tx_wr) chk("R8 echo data", tx_data, rx_data);
      end
      rx_empty = 1'b1; tx_full = 1'b0;
      reg_write(2'd0, 32'd3);
      reg_read(2'd1, v); chk("R8 start ignored in responder", v[0], 0);
      reg_read(2'd3, v); chk("R8 tag unchanged", v, exp_tag);
      reg_write(2'd0, 32'd0);
      reg_read(2'd0, v); chk("R8 back to initiator", v, 0);
      run_meas(1, 5, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 190000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule